// File: doc/BRIEF.md
# Multi-Port GPIO Register Bank

This block is a memory-mapped general-purpose I/O controller made of several ports, each `PIN_W` pins wide (24 by default). Each pin can be used in three ways: as a plain input, as a plain output driven from a software-written value, or as an output handed to another on-chip function that supplies its own value and enable. Per-pin control bits select the direction and the source. Two further bits make the pin open-drain or invert its driven value.

A simple word-addressed bus writes and reads the control words. Five banks of words are spaced `STRIDE` words apart, with one word per port inside each bank. The block drives a value and an output enable to each pad buffer. It samples every pad level back through a two-flop synchronizer, so a read of the data bank always shows the real level on the pin, including pins that the block is driving.

Top module: `gpio_bank`

## Requirements
- R1: Word address `bank*STRIDE + port` selects a register. STRIDE defaults to 4. Bank 0 is data, bank 1 is direction, bank 2 is source select, bank 3 is open-drain and bank 4 is invert. Bit i of a word belongs to pin `port*PIN_W + i`.
- R2: After reset, every direction, source-select, open-drain, invert and data bit is 0, and `pad_oe` is all zero.
- R3: A pin with source select 0 and direction 1 drives `pad_oe`=1 and its data bit on `pad_out`, provided open-drain and invert are both 0. A pin with source select 0 and direction 0 has `pad_oe`=0.
- R4: An invert bit of 1 inverts the value a pin drives. On a pin that is not driving, the invert bit changes neither `pad_oe` nor `pad_out`.
- R5: With open-drain set on a driving pin, a final value of 0 gives `pad_oe`=1 and `pad_out`=0, and a final value of 1 gives `pad_oe`=0. The pin never drives high.
- R6: `pad_out` is 0 on every pin whose `pad_oe` is 0.
- R7: With source select 1, the pin's value comes from `alt_out` and its enable from `alt_oe`, and the direction bit is ignored. Invert and open-drain still apply to that value.
- R8: A read of the data bank returns `pad_in` through two synchronizer flops. A pad change is not visible to a read whose capture edge is the second edge after the change. It is visible from the third edge on.
- R9: A read of banks 1 to 4 returns the value last written to that word.
- R10: Only bits [PIN_W-1:0] of a word are stored. Higher bits are ignored on write and read as 0.
- R11: `rdata` carries the addressed word in the cycle after a cycle with `rd_en`=1, and is 0 otherwise. Addresses with bank above 4 or port at or above NPORT read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| pad_in | input | NPORT*PIN_W | Pad levels |
| pad_out | output | NPORT*PIN_W | Value to pad buffers |
| pad_oe | output | NPORT*PIN_W | Output enable to pad buffers |
| alt_out | input | NPORT*PIN_W | Value from the alternate function |
| alt_oe | input | NPORT*PIN_W | Enable from the alternate function |

## Verification
The hardest case to reach is a pin where all four control bits interact with the alternate-function inputs. Open-drain combined with invert on a pin that is routed to the alternate function is the clearest example. The bench first sweeps all 128 combinations of the seven per-pin inputs, replicated across every pin. It then applies pseudo-random words, so that neighbouring pins hold different mixes, and compares both pad vectors against a bitwise model. Synchronizer timing is checked by reading the data bank directly after a pad change and then once more.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NPORT = 2,
  parameter int PIN_W = 24,
  parameter int STRIDE_LOG2 = 2,
  localparam int NPIN = NPORT * PIN_W,
  localparam int ADDR_W = STRIDE_LOG2 + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  input  logic [NPIN-1:0]   alt_out,
  input  logic [NPIN-1:0]   alt_oe
);

  logic [2:0] bank;
  logic [STRIDE_LOG2-1:0] pidx;
  assign bank = addr[ADDR_W-1:STRIDE_LOG2];
  assign pidx = addr[STRIDE_LOG2-1:0];

  logic [NPIN-1:0] dout_f, dir_f, alt_f, od_f, inv_f;
  logic [NPIN-1:0] sync1, sync2;
  logic [PIN_W-1:0] rd_word, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_f <= '0;
      dir_f  <= '0;
      alt_f  <= '0;
      od_f   <= '0;
      inv_f  <= '0;
    end else if (wr_en) begin
      for (int p = 0; p < NPORT; p++) begin
        if (pidx == STRIDE_LOG2'(p)) begin
          case (bank)
            3'd0: dout_f[p*PIN_W +: PIN_W] <= wdata[PIN_W-1:0];
            3'd1: dir_f[p*PIN_W +: PIN_W]  <= wdata[PIN_W-1:0];
            3'd2: alt_f[p*PIN_W +: PIN_W]  <= wdata[PIN_W-1:0];
            3'd3: od_f[p*PIN_W +: PIN_W]   <= wdata[PIN_W-1:0];
            3'd4: inv_f[p*PIN_W +: PIN_W]  <= wdata[PIN_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (pidx == STRIDE_LOG2'(p)) begin
        case (bank)
          3'd0: rd_word = sync2[p*PIN_W +: PIN_W];
          3'd1: rd_word = dir_f[p*PIN_W +: PIN_W];
          3'd2: rd_word = alt_f[p*PIN_W +: PIN_W];
          3'd3: rd_word = od_f[p*PIN_W +: PIN_W];
          3'd4: rd_word = inv_f[p*PIN_W +: PIN_W];
          default: rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else if (rd_en) rd_q <= rd_word;
    else rd_q <= '0;
  end

  assign rdata = 32'(rd_q);

  logic [NPIN-1:0] src_v, src_en, fin_v;
  assign src_v   = (alt_f & alt_out) | (~alt_f & dout_f);
  assign src_en  = (alt_f & alt_oe) | (~alt_f & dir_f);
  assign fin_v   = src_v ^ inv_f;
  assign pad_oe  = src_en & ~(od_f & fin_v);
  assign pad_out = src_en & fin_v & ~od_f;

endmodule

module gpio_bank_chk #(
  parameter int NPIN = 48,
  parameter int PIN_W = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_en,
  input logic [31:0]     rdata,
  input logic [NPIN-1:0] pad_out,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] dir_f,
  input logic [NPIN-1:0] alt_f,
  input logic [NPIN-1:0] od_f
);

  a_r5_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    (od_f & pad_oe & pad_out) == '0);

  a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  a_r3_input_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir_f & ~alt_f) == '0);

  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata >> PIN_W) == 32'd0);

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rdata == 32'd0);

endmodule

bind gpio_bank gpio_bank_chk #(.NPIN(NPIN), .PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rdata(rdata),
  .pad_out(pad_out), .pad_oe(pad_oe),
  .dir_f(dir_f), .alt_f(alt_f), .od_f(od_f)
);

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
  localparam int NPORT = 2;
  localparam int PIN_W = 24;
  localparam int NPIN = NPORT * PIN_W;
  localparam int STR = 4;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NPIN-1:0] pad_in = '0, pad_out, pad_oe, alt_out = '0, alt_oe = '0;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  gpio_bank #(.NPORT(NPORT), .PIN_W(PIN_W), .STRIDE_LOG2(2)) i_gpio_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [NPIN-1:0] got, input logic [NPIN-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = 5'(a); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = 5'(a);
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  function automatic logic [31:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  logic [NPIN-1:0] m_dout, m_dir, m_alt, m_od, m_inv;

  task automatic load_all();
    for (int p = 0; p < NPORT; p++) begin
      wr(0*STR + p, 32'(m_dout[p*PIN_W +: PIN_W]));
      wr(1*STR + p, 32'(m_dir[p*PIN_W +: PIN_W]));
      wr(2*STR + p, 32'(m_alt[p*PIN_W +: PIN_W]));
      wr(3*STR + p, 32'(m_od[p*PIN_W +: PIN_W]));
      wr(4*STR + p, 32'(m_inv[p*PIN_W +: PIN_W]));
    end
  endtask

  task automatic check_pads(input string tag);
    logic [NPIN-1:0] v, en, eoe, eout;
    v = 0; en = 0; eoe = 0; eout = 0;
    for (int i = 0; i < NPIN; i++) begin
      v[i]  = (m_alt[i] ? alt_out[i] : m_dout[i]) ^ m_inv[i];
      en[i] = m_alt[i] ? alt_oe[i] : m_dir[i];
      if (en[i]) begin
        if (m_od[i]) begin eoe[i] = !v[i]; eout[i] = 0; end
        else begin eoe[i] = 1; eout[i] = v[i]; end
      end
    end
    chk({tag, " oe"}, pad_oe, eoe);
    chk({tag, " out"}, pad_out, eout);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    chk("R2 pad_oe after reset", pad_oe, '0);
    for (int b = 1; b < 5; b++)
      for (int p = 0; p < NPORT; p++) begin
        rd(b*STR + p, d); chk("R2 reset register", NPIN'(d), '0);
      end

    // R9 / R10 readback
    wr(1*STR + 0, 32'hFFFF_FFFF);
    rd(1*STR + 0, d); chk("R10 upper bits dropped", NPIN'(d), NPIN'(32'h00FF_FFFF));
    @(negedge clk); chk("R11 rdata idle zero", NPIN'(rdata), '0);
    for (int b = 1; b < 5; b++)
      for (int p = 0; p < NPORT; p++) begin
        logic [31:0] w;
        w = rnd() & 32'h00FF_FFFF;
        wr(b*STR + p, w); rd(b*STR + p, d);
        chk("R9 R1 readback", NPIN'(d), NPIN'(w));
      end

    // R11 unmapped addresses
    for (int b = 1; b < 5; b++)
      for (int p = 0; p < NPORT; p++) wr(b*STR + p, 0);
    wr(5*STR + 0, 32'hFFFF_FFFF);
    wr(1*STR + 2, 32'hFFFF_FFFF);
    wr(7*STR + 3, 32'hFFFF_FFFF);
    chk("R11 unmapped write no effect", pad_oe, '0);
    rd(5*STR + 0, d); chk("R11 unmapped bank reads 0", NPIN'(d), '0);
    rd(1*STR + 2, d); chk("R11 unmapped port reads 0", NPIN'(d), '0);
    rd(1*STR + 1, d); chk("R11 unmapped write kept port 1", NPIN'(d), '0);

    // R3-R7 exhaustive per-pin combos, replicated
    for (int c = 0; c < 128; c++) begin
      m_dout = {NPIN{c[0]}}; m_dir = {NPIN{c[1]}}; m_alt = {NPIN{c[2]}};
      m_od = {NPIN{c[3]}}; m_inv = {NPIN{c[4]}};
      alt_out = {NPIN{c[5]}}; alt_oe = {NPIN{c[6]}};
      load_all();
      check_pads("R3 R4 R5 R6 R7 sweep");
    end

    // mixed pseudo-random patterns
    for (int k = 0; k < 40; k++) begin
      m_dout = {rnd(), rnd()}; m_dir = {rnd(), rnd()}; m_alt = {rnd(), rnd()};
      m_od = {rnd(), rnd()}; m_inv = {rnd(), rnd()};
      alt_out = {rnd(), rnd()}; alt_oe = {rnd(), rnd()};
      load_all();
      check_pads("R3 R4 R5 R6 R7 mixed");
      alt_out = {rnd(), rnd()}; alt_oe = {rnd(), rnd()};
      @(negedge clk);
      check_pads("R7 alt inputs change");
    end

    // R4 invert on input pins has no effect
    m_dout = {NPIN{1'b1}}; m_dir = '0; m_alt = '0; m_od = '0; m_inv = {NPIN{1'b1}};
    load_all();
    chk("R4 invert on input oe", pad_oe, '0);
    chk("R4 invert on input out", pad_out, '0);

    // R8 synchronizer and live readback
    for (int k = 0; k < 8; k++) begin
      logic [NPIN-1:0] old_v, new_v;
      old_v = pad_in;
      new_v = {rnd(), rnd()};
      @(negedge clk); pad_in = new_v;
      for (int p = 0; p < NPORT; p++) begin
        if (p == 0) begin
          rd(0*STR + 0, d);
          chk("R8 not yet visible", NPIN'(d), NPIN'(old_v[PIN_W-1:0]));
        end
        rd(0*STR + p, d);
        chk("R8 data readback", NPIN'(d), NPIN'(new_v[p*PIN_W +: PIN_W]));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule